// File: doc/BRIEF.md
# Two-Sided Mailbox Messaging Unit

This block lets two processors, called side A and side B, pass 32-bit words to each other through a shared mailbox. Both sides run on the same clock. Each side has its own small register bus. On that bus it sees four outgoing data registers, four incoming data registers, a status word and a control word. A word that one side writes into outgoing slot n shows up in incoming slot n of the other side. A handshake flag for each slot tells the sender when the slot is free and tells the receiver when a word is waiting.

Software on either side polls the status word or waits for its interrupt line. The control word sets which slot events raise that side's interrupt. It also carries four general-purpose requests that the peer can take as interrupts, and three plain flag bits that the peer reads back in its status word. A message longer than one word is sent by going around the slots in turn, and each slot is refilled only after the receiver has drained it.

Word addresses on each bus are as follows: 0 to 3 are the outgoing slots, 4 to 7 are the incoming slots, 8 is status and 9 is control. Read data is combinational from the address. Writes, and the side effects of reads, take effect at the next rising clock edge.

Top module: `msgu_top`

## Requirements
- R1: After reset, both status words read 0x00F00000: every slot-free flag is set, no word-waiting flag is set and all peer fields are 0. Both control words read 0 and both interrupt lines are low.
- R2: A write to outgoing slot n (address n) on a side whose slot-free flag (status bit 23-n) is set does three things. It clears that flag, sets the peer's word-waiting flag (status bit 27-n), and makes the word readable at the peer's address 4+n.
- R3: A read of incoming slot n while its waiting flag is set clears that flag and sets the sender's slot-free flag again. A read while the flag is clear returns the held word and changes no flag.
- R4: A write to an outgoing slot whose free flag is clear is dropped, and the word already pending in that slot is delivered unchanged.
- R5: The B-to-A direction behaves the same as A-to-B and is independent of it. A word that B sends does not touch the A-to-B flags.
- R6: The control word keeps bits 31:16 and 2:0, and all other bits read back as 0. Writing 0 clears every enable, request and flag bit.
- R7: Status bits 2:0 of one side show control bits 2:0 of the other side.
- R8: Control bit 24+n enables a side's interrupt when its incoming slot n holds a waiting word.
- R9: Control bit 20+n enables a side's interrupt when its outgoing slot n is free.
- R10: Control bit 16+k on one side raises a general request k. The peer sees this request at status bit 16+k, and its interrupt is driven when the peer's own control bit 28+k is set.
- R11: If the sender writes slot n in the same cycle that the receiver drains the full slot n, the receiver gets the old word, the new word is dropped, and the slot ends free.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Common clock |
| rst_n | input | 1 | Active-low synchronous reset |
| a_wr | input | 1 | Side A write strobe |
| a_rd | input | 1 | Side A read strobe (drains an incoming slot) |
| a_addr | input | 4 | Side A word address |
| a_wdata | input | 32 | Side A write data |
| a_rdata | output | 32 | Side A read data, combinational |
| a_irq | output | 1 | Side A interrupt |
| b_wr | input | 1 | Side B write strobe |
| b_rd | input | 1 | Side B read strobe (drains an incoming slot) |
| b_addr | input | 4 | Side B word address |
| b_wdata | input | 32 | Side B write data |
| b_rdata | output | 32 | Side B read data, combinational |
| b_irq | output | 1 | Side B interrupt |

## Verification
Two actions can land on the same slot in one cycle. One is the sender writing a slot. The other is the receiver draining that same slot. The bench first fills a slot, then drives both buses in a single cycle: a new write from A and a drain read from B. It passes only if B receives the first word and the slot ends free. A second read must still return the first word, which shows the late write never landed.

// File: rtl/msgu_pkg.sv
package msgu_pkg;

  localparam int WORD_W   = 32;
  localparam int GEN_N    = 4;
  localparam int FLAG_W   = 3;
  localparam int SLOT_MAX = 4;

  localparam int GIE_LSB  = 28;
  localparam int RIE_LSB  = 24;
  localparam int TIE_LSB  = 20;
  localparam int GIR_LSB  = 16;

  localparam logic [WORD_W-1:0] CTRL_KEEP = 32'hFFFF_0007;

  function automatic int free_pos(int n);
    return 23 - n;
  endfunction

  function automatic int wait_pos(int n);
    return 27 - n;
  endfunction

  function automatic logic [WORD_W-1:0] pack_status(
    logic [SLOT_MAX-1:0] free_v,
    logic [SLOT_MAX-1:0] wait_v,
    logic [GEN_N-1:0]    gen_in,
    logic [FLAG_W-1:0]   flags_in
  );
    logic [WORD_W-1:0] s;
    s = '0;
    for (int n = 0; n < SLOT_MAX; n++) begin
      s[free_pos(n)] = free_v[n];
      s[wait_pos(n)] = wait_v[n];
    end
    s[GIR_LSB +: GEN_N] = gen_in;
    s[FLAG_W-1:0]       = flags_in;
    return s;
  endfunction

  function automatic logic irq_eval(
    logic [SLOT_MAX-1:0] wait_v,
    logic [SLOT_MAX-1:0] rx_en,
    logic [SLOT_MAX-1:0] free_v,
    logic [SLOT_MAX-1:0] tx_en,
    logic [GEN_N-1:0]    gen_in,
    logic [GEN_N-1:0]    gen_en
  );
    return (|(wait_v & rx_en)) | (|(free_v & tx_en)) | (|(gen_in & gen_en));
  endfunction

endpackage

// File: rtl/msgu_slots.sv
module msgu_slots
  import msgu_pkg::*;
#(
  parameter int NCH = 4
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [NCH-1:0]               push,
  input  logic [WORD_W-1:0]            push_word,
  input  logic [NCH-1:0]               pop,
  output logic [NCH-1:0]               full,
  output logic [NCH-1:0][WORD_W-1:0]   held
);

  for (genvar n = 0; n < NCH; n++) begin : g_slot
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        full[n] <= 1'b0;
        held[n] <= '0;
      end else if (push[n]) begin
        full[n] <= 1'b1;
        held[n] <= push_word;
      end else if (pop[n]) begin
        full[n] <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/msgu_side.sv
module msgu_side
  import msgu_pkg::*;
#(
  parameter int NCH = 4,
  parameter int AW  = 4
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        bus_wr,
  input  logic                        bus_rd,
  input  logic [AW-1:0]               bus_addr,
  input  logic [WORD_W-1:0]           bus_wdata,
  output logic [WORD_W-1:0]           bus_rdata,
  output logic                        irq,
  input  logic [NCH-1:0]              tx_free,
  input  logic [NCH-1:0]              rx_wait,
  input  logic [NCH-1:0][WORD_W-1:0]  rx_word,
  input  logic [GEN_N-1:0]            peer_gen,
  input  logic [FLAG_W-1:0]           peer_flags,
  output logic [NCH-1:0]              tx_push,
  output logic [NCH-1:0]              rx_pop,
  output logic [GEN_N-1:0]            own_gen,
  output logic [FLAG_W-1:0]           own_flags
);

  localparam int STAT_IDX = 2 * NCH;
  localparam int CTRL_IDX = 2 * NCH + 1;

  logic [WORD_W-1:0]   ctrl_q;
  logic                ctrl_wr;
  logic [SLOT_MAX-1:0] free4, wait4;
  logic [WORD_W-1:0]   status_w;

  for (genvar n = 0; n < NCH; n++) begin : g_dec
    assign tx_push[n] = bus_wr && (bus_addr == AW'(n)) && tx_free[n];
    assign rx_pop[n]  = bus_rd && (bus_addr == AW'(NCH + n)) && rx_wait[n];
  end

  for (genvar n = 0; n < SLOT_MAX; n++) begin : g_pad
    if (n < NCH) begin : g_live
      assign free4[n] = tx_free[n];
      assign wait4[n] = rx_wait[n];
    end else begin : g_tie
      assign free4[n] = 1'b0;
      assign wait4[n] = 1'b0;
    end
  end

  assign ctrl_wr = bus_wr && (bus_addr == AW'(CTRL_IDX));

  always_ff @(posedge clk) begin
    if (!rst_n) ctrl_q <= '0;
    else if (ctrl_wr) ctrl_q <= bus_wdata & CTRL_KEEP;
  end

  assign own_gen   = ctrl_q[GIR_LSB +: GEN_N];
  assign own_flags = ctrl_q[FLAG_W-1:0];

  assign status_w = pack_status(free4, wait4, peer_gen, peer_flags);

  always_comb begin
    bus_rdata = '0;
    for (int n = 0; n < NCH; n++) begin
      if (bus_addr == AW'(NCH + n)) bus_rdata = rx_word[n];
    end
    if (bus_addr == AW'(STAT_IDX)) bus_rdata = status_w;
    if (bus_addr == AW'(CTRL_IDX)) bus_rdata = ctrl_q;
  end

  assign irq = irq_eval(wait4, ctrl_q[RIE_LSB +: SLOT_MAX], free4,
                        ctrl_q[TIE_LSB +: SLOT_MAX], peer_gen,
                        ctrl_q[GIE_LSB +: GEN_N]);

endmodule

// File: rtl/msgu_top.sv
module msgu_top
  import msgu_pkg::*;
#(
  parameter  int NCH = 4,
  localparam int AW  = $clog2(2 * NCH + 2)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              a_wr,
  input  logic              a_rd,
  input  logic [AW-1:0]     a_addr,
  input  logic [WORD_W-1:0] a_wdata,
  output logic [WORD_W-1:0] a_rdata,
  output logic              a_irq,
  input  logic              b_wr,
  input  logic              b_rd,
  input  logic [AW-1:0]     b_addr,
  input  logic [WORD_W-1:0] b_wdata,
  output logic [WORD_W-1:0] b_rdata,
  output logic              b_irq
);

  logic [NCH-1:0]             ab_full, ba_full;
  logic [NCH-1:0][WORD_W-1:0] ab_data, ba_data;
  logic [NCH-1:0]             a_push, a_pop, b_push, b_pop;
  logic [GEN_N-1:0]           a_gen, b_gen;
  logic [FLAG_W-1:0]          a_flags, b_flags;

  msgu_slots #(.NCH(NCH)) u_ab (
    .clk(clk), .rst_n(rst_n), .push(a_push), .push_word(a_wdata),
    .pop(b_pop), .full(ab_full), .held(ab_data)
  );

  msgu_slots #(.NCH(NCH)) u_ba (
    .clk(clk), .rst_n(rst_n), .push(b_push), .push_word(b_wdata),
    .pop(a_pop), .full(ba_full), .held(ba_data)
  );

  msgu_side #(.NCH(NCH), .AW(AW)) u_side_a (
    .clk(clk), .rst_n(rst_n), .bus_wr(a_wr), .bus_rd(a_rd),
    .bus_addr(a_addr), .bus_wdata(a_wdata), .bus_rdata(a_rdata), .irq(a_irq),
    .tx_free(~ab_full), .rx_wait(ba_full), .rx_word(ba_data),
    .peer_gen(b_gen), .peer_flags(b_flags),
    .tx_push(a_push), .rx_pop(a_pop), .own_gen(a_gen), .own_flags(a_flags)
  );

  msgu_side #(.NCH(NCH), .AW(AW)) u_side_b (
    .clk(clk), .rst_n(rst_n), .bus_wr(b_wr), .bus_rd(b_rd),
    .bus_addr(b_addr), .bus_wdata(b_wdata), .bus_rdata(b_rdata), .irq(b_irq),
    .tx_free(~ba_full), .rx_wait(ab_full), .rx_word(ab_data),
    .peer_gen(a_gen), .peer_flags(a_flags),
    .tx_push(b_push), .rx_pop(b_pop), .own_gen(b_gen), .own_flags(b_flags)
  );

endmodule

// File: rtl/msgu_checker.sv
module msgu_checker
  import msgu_pkg::*;
#(
  parameter int NCH = 4,
  parameter int AW  = 4
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       a_wr,
  input logic [AW-1:0]              a_addr,
  input logic [WORD_W-1:0]          a_wdata,
  input logic [NCH-1:0]             ab_full,
  input logic [NCH-1:0]             ba_full,
  input logic [NCH-1:0][WORD_W-1:0] ab_data,
  input logic [NCH-1:0]             a_push,
  input logic [NCH-1:0]             b_push,
  input logic [NCH-1:0]             b_pop,
  input logic [WORD_W-1:0]          a_ctrl,
  input logic [WORD_W-1:0]          b_ctrl,
  input logic                       a_irq,
  input logic                       b_irq
);

  logic a_ctrl_wr;
  assign a_ctrl_wr = a_wr && (a_addr == AW'(2 * NCH + 1));

  p_reset_clear_r1: assert property (@(posedge clk)
    !rst_n |=> (ab_full == '0 && ba_full == '0));

  for (genvar n = 0; n < NCH; n++) begin : g_ch
    p_fill_r2: assert property (@(posedge clk) disable iff (!rst_n)
      a_push[n] |=> ab_full[n]);
    p_drain_r3: assert property (@(posedge clk) disable iff (!rst_n)
      b_pop[n] |=> !ab_full[n]);
    p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (ab_full[n] && !b_pop[n]) |=> (ab_full[n] && $stable(ab_data[n])));
    p_fill_back_r5: assert property (@(posedge clk) disable iff (!rst_n)
      b_push[n] |=> ba_full[n]);
  end

  p_ctrl_mask_r6: assert property (@(posedge clk) disable iff (!rst_n)
    a_ctrl_wr |=> (a_ctrl == ($past(a_wdata) & CTRL_KEEP)));

  p_irq_rx_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (|(ab_full & b_ctrl[RIE_LSB +: NCH])) |-> b_irq);

  p_irq_tx_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (|(~ab_full & a_ctrl[TIE_LSB +: NCH])) |-> a_irq);

  p_irq_gen_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (|(a_ctrl[GIR_LSB +: GEN_N] & b_ctrl[GIE_LSB +: GEN_N])) |-> b_irq);

endmodule

bind msgu_top msgu_checker #(.NCH(NCH), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .a_wr(a_wr), .a_addr(a_addr), .a_wdata(a_wdata),
  .ab_full(ab_full), .ba_full(ba_full), .ab_data(ab_data),
  .a_push(a_push), .b_push(b_push), .b_pop(b_pop),
  .a_ctrl(u_side_a.ctrl_q), .b_ctrl(u_side_b.ctrl_q),
  .a_irq(a_irq), .b_irq(b_irq)
);

// File: tb/tb_msgu_top.sv
module tb_msgu_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        a_wr = 0, a_rd = 0, b_wr = 0, b_rd = 0;
  logic [3:0]  a_addr = 0, b_addr = 0;
  logic [31:0] a_wdata = 0, b_wdata = 0;
  logic [31:0] a_rdata, b_rdata;
  logic        a_irq, b_irq;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  localparam logic [31:0] IDLE_ST = 32'h00F0_0000;

  msgu_top dut (
    .clk(clk), .rst_n(rst_n),
    .a_wr(a_wr), .a_rd(a_rd), .a_addr(a_addr), .a_wdata(a_wdata),
    .a_rdata(a_rdata), .a_irq(a_irq),
    .b_wr(b_wr), .b_rd(b_rd), .b_addr(b_addr), .b_wdata(b_wdata),
    .b_rdata(b_rdata), .b_irq(b_irq)
  );

  always #4 clk = ~clk;

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  task automatic check_eq(input string req, input logic [31:0] act,
                          input logic [31:0] exp);
    check(act === exp, req, act, exp);
  endtask

  // One bus cycle on both sides; read data captured before the edge.
  task automatic cyc(input bit awr, input bit ard, input logic [3:0] aad,
                     input logic [31:0] awd, input bit bwr, input bit brd,
                     input logic [3:0] bad, input logic [31:0] bwd,
                     output logic [31:0] ard_v, output logic [31:0] brd_v);
    @(negedge clk);
    a_wr = awr; a_rd = ard; a_addr = aad; a_wdata = awd;
    b_wr = bwr; b_rd = brd; b_addr = bad; b_wdata = bwd;
    #1;
    ard_v = a_rdata;
    brd_v = b_rdata;
    @(posedge clk);
    #1;
    a_wr = 0; a_rd = 0; b_wr = 0; b_rd = 0;
  endtask

  task automatic wr(input bit side_b, input logic [3:0] ad, input logic [31:0] d);
    logic [31:0] x, y;
    if (side_b) cyc(0, 0, 0, 0, 1, 0, ad, d, x, y);
    else        cyc(1, 0, ad, d, 0, 0, 0, 0, x, y);
  endtask

  task automatic rd(input bit side_b, input logic [3:0] ad, output logic [31:0] d);
    logic [31:0] x, y;
    if (side_b) cyc(0, 0, 0, 0, 0, 1, ad, 0, x, y);
    else        cyc(0, 1, ad, 0, 0, 0, 0, 0, x, y);
    d = side_b ? y : x;
  endtask

  task automatic t_reset();
    logic [31:0] v;
    rd(0, 8, v); check_eq("R1 A status", v, IDLE_ST);
    rd(1, 8, v); check_eq("R1 B status", v, IDLE_ST);
    rd(0, 9, v); check_eq("R1 A control", v, 0);
    rd(1, 9, v); check_eq("R1 B control", v, 0);
    check_eq("R1 irqs", {30'd0, a_irq, b_irq}, 0);
  endtask

  task automatic t_transfer();
    logic [31:0] v;
    wr(0, 1, 32'hDEAD_0001);
    rd(0, 8, v); check_eq("R2 A free flag 22 clear", v, 32'h00B0_0000);
    rd(1, 8, v); check_eq("R2 B wait flag 26 set", v, 32'h04F0_0000);
    rd(1, 5, v); check_eq("R2 B slot 1 data", v, 32'hDEAD_0001);
    rd(1, 8, v); check_eq("R3 B wait cleared", v, IDLE_ST);
    rd(0, 8, v); check_eq("R3 A free restored", v, IDLE_ST);
    rd(1, 5, v); check_eq("R3 read while empty returns held word", v, 32'hDEAD_0001);
    rd(0, 8, v); check_eq("R3 empty read leaves flags", v, IDLE_ST);
  endtask

  task automatic t_ignore();
    logic [31:0] v;
    wr(0, 0, 32'h0000_0011);
    wr(0, 0, 32'h0000_0022);
    rd(1, 4, v); check_eq("R4 pending word kept", v, 32'h0000_0011);
    rd(0, 8, v); check_eq("R4 flags after drain", v, IDLE_ST);
  endtask

  task automatic t_reverse();
    logic [31:0] v;
    wr(1, 3, 32'h3333_0033);
    rd(0, 8, v); check_eq("R5 A wait flag 24", v, 32'h01F0_0000);
    rd(1, 8, v); check_eq("R5 B free flag 20 clear", v, 32'h00E0_0000);
    rd(0, 7, v); check_eq("R5 A slot 3 data", v, 32'h3333_0033);
    rd(1, 8, v); check_eq("R5 B free restored", v, IDLE_ST);
  endtask

  task automatic t_ctrl();
    logic [31:0] v;
    wr(0, 9, 32'hFFFF_FFFF);
    rd(0, 9, v); check_eq("R6 control mask", v, 32'hFFFF_0007);
    wr(0, 9, 32'h0);
    rd(0, 9, v); check_eq("R6 control cleared", v, 32'h0);
    check_eq("R6 irqs low after clear", {30'd0, a_irq, b_irq}, 0);
  endtask

  task automatic t_flags();
    logic [31:0] v;
    wr(0, 9, 32'h0000_0005);
    rd(1, 8, v); check_eq("R7 B sees A flags", v, 32'h00F0_0005);
    rd(0, 8, v); check_eq("R7 A status untouched", v, IDLE_ST);
    wr(0, 9, 32'h0);
  endtask

  task automatic t_irq_rx();
    logic [31:0] v;
    wr(1, 9, 32'h0400_0000);
    check_eq("R8 B irq idle", {31'd0, b_irq}, 0);
    wr(0, 2, 32'h0000_2222);
    check_eq("R8 B irq on wait", {31'd0, b_irq}, 1);
    rd(1, 6, v);
    check_eq("R8 B irq after drain", {31'd0, b_irq}, 0);
    wr(1, 9, 32'h0);
  endtask

  task automatic t_irq_tx();
    logic [31:0] v;
    wr(0, 9, 32'h0020_0000);
    check_eq("R9 A irq slot free", {31'd0, a_irq}, 1);
    wr(0, 1, 32'h0000_1111);
    check_eq("R9 A irq slot busy", {31'd0, a_irq}, 0);
    rd(1, 5, v);
    check_eq("R9 A irq free again", {31'd0, a_irq}, 1);
    wr(0, 9, 32'h0);
  endtask

  task automatic t_general();
    logic [31:0] v;
    wr(1, 9, 32'h4000_0000);
    check_eq("R10 B irq before request", {31'd0, b_irq}, 0);
    wr(0, 9, 32'h0004_0000);
    rd(1, 8, v); check_eq("R10 B status gen bit 18", v, 32'h00F4_0000);
    check_eq("R10 irqs A=0 B=1", {30'd0, a_irq, b_irq}, 1);
    wr(0, 9, 32'h0);
    check_eq("R10 B irq after withdraw", {31'd0, b_irq}, 0);
    wr(1, 9, 32'h0);
  endtask

  task automatic t_collide();
    logic [31:0] x, y, v;
    wr(0, 3, 32'h0000_AAAA);
    cyc(1, 0, 3, 32'h0000_BBBB, 0, 1, 7, 0, x, y);
    check_eq("R11 receiver gets old word", y, 32'h0000_AAAA);
    rd(0, 8, v); check_eq("R11 A slot ends free", v, IDLE_ST);
    rd(1, 8, v); check_eq("R11 B nothing waiting", v, IDLE_ST);
    rd(1, 7, v); check_eq("R11 late write dropped", v, 32'h0000_AAAA);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    t_reset();
    t_transfer();
    t_ignore();
    t_reverse();
    t_ctrl();
    t_flags();
    t_irq_rx();
    t_irq_tx();
    t_general();
    t_collide();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule